// File: doc/BRIEF.md
# Buffered Compare/Capture Timer Channel

This block is one channel that sits beside a 16-bit timer counter. The counter may count up, down or up/down. The block reads the counter value and the count mode, and it runs in one of two modes.

In comparator mode, software writes a value into the channel register. That value moves into a shadow compare buffer at a moment chosen by a 3-bit buffer-mode code. Each cycle the counter is compared with the buffer. An equal count raises a registered match pulse. Some codes also raise a reload request, which asks the counter to restart.

In capture mode, one of several trigger lines is selected. The line is synchronised, and its rising edge, falling edge or both latch the counter into the channel register. The capture can be taken in the same cycle the edge is seen, or one cycle later. A flag marks each capture. A second flag marks a capture that arrives while the first flag is still set.

Top module: `cc_channel`

## Requirements
- R1: After reset, all of the following are 0: the match pulse, the reload request, the captured value, the capture flag, the overflow flag and the compare buffer.
- R2: In comparator mode (`capture_en`=0), `match_o` is high for exactly the cycle after an edge where `cnt_val` equals the compare buffer as it stood before that edge.
- R3: Buffer code 0: the channel register takes `wr_data` at the edge that samples `wr_en`. The buffer copies the channel register at every edge, so the new value is in the buffer one edge after the write.
- R4: Buffer code 1 copies the channel register into the buffer at an edge where `cnt_val` is 0 in up mode (`cnt_mode`=00). In down mode (01) it copies where `cnt_val` equals `cnt_max`. In up/down mode (10 or 11) it copies at either of those values.
- R5: Buffer code 2 copies the channel register into the buffer at an edge where `cnt_val` matches the buffer or `cnt_val` is 0.
- R6: Buffer codes 3 and 4 copy the channel register into the buffer only at an edge where `cnt_val` matches the buffer. In the same cycle as the match pulse, `reload_o` is raised, but only in up or down mode and never in up/down mode. No other code raises `reload_o`.
- R7: Buffer codes 5, 6 and 7 never change the buffer.
- R8: In capture mode, `match_o` stays 0 and the buffer holds its value. In comparator mode, trigger edges do not change the channel register or the flags.
- R9: `trig_sel` picks which bit of `trig_in` is used. `edge_sel` chooses the active edges: 00 is none, 01 is rising, 10 is falling and 11 is both. Edges are seen after a two-flop synchroniser.
- R10: With `sync_cap`=0, suppose the trigger changes before clock edge 1. The channel register then takes the `cnt_val` presented before edge 3, and the flag is set after edge 3.
- R11: With `sync_cap`=1, the capture happens one edge later than under R10. The channel register takes the `cnt_val` presented before edge 4.
- R12: `cap_flag_o` is set on each capture. A `flag_clr` pulse clears it, and the same pulse also clears `cap_ovf_o`. `cap_ovf_o` is set when a capture arrives while the flag is still set and no clear is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | 1 = capture mode, 0 = comparator mode |
| sync_cap | input | 1 | 1 = capture one cycle after edge detection, 0 = capture in the detection cycle |
| cnt_mode | input | 2 | 00 up, 01 down, 10/11 up/down |
| buf_mode | input | 3 | Compare-buffer load code |
| trig_sel | input | TSW | Trigger line select |
| edge_sel | input | 2 | Active trigger edges |
| trig_in | input | NTRIG | Trigger lines |
| cnt_val | input | CW | Current counter value |
| cnt_max | input | CW | Counter top value |
| wr_en | input | 1 | Channel register write strobe |
| wr_data | input | CW | Channel register write data |
| flag_clr | input | 1 | Clears the capture and overflow flags |
| match_o | output | 1 | Compare match pulse |
| reload_o | output | 1 | Counter reload request |
| cap_val_o | output | CW | Channel register value (written or captured) |
| cap_flag_o | output | 1 | Capture flag |
| cap_ovf_o | output | 1 | Capture overflow flag |

## Verification
A buffer that loads at the wrong moment shows up at the ports on the next comparison: a match comes one cycle early, one cycle late, or never. The vector table lets the buffer contents carry over from each row to the next, so every load has to be proved by a later match row. A wrong synchroniser depth or capture alignment changes the captured counter value in the very cycle the flag rises, because the counter input moves every cycle during those tests. Missed flag or overflow state appears at the ports within one edge of the capture that should have set it.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        CM_UP       = 2'd0,
        CM_DOWN     = 2'd1,
        CM_UPDN     = 2'd2,
        CM_UPDN_ALT = 2'd3
    } cnt_mode_e;

    typedef enum logic [2:0] {
        BM_IMMED      = 3'd0,
        BM_WRAP       = 3'd1,
        BM_MATCH_ZERO = 3'd2,
        BM_MATCH_RST  = 3'd3,
        BM_MATCH_RLD  = 3'd4,
        BM_RSV5       = 3'd5,
        BM_RSV6       = 3'd6,
        BM_RSV7       = 3'd7
    } buf_mode_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/cc_trig_detect.sv
module cc_trig_detect #(
    parameter int NTRIG = 4,
    localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [TSW-1:0]   trig_sel,
    input  logic [1:0]       edge_sel,
    output logic             edge_hit
);
    import cc_pkg::*;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  line_sel;
    logic  rise_seen;
    logic  fall_seen;

    always_comb begin
        line_sel = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (TSW'(i) == trig_sel) line_sel = trig_in[i];
        end
        sync_d    = sync_q;
        sync_d.s1 = line_sel;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
        rise_seen = sync_q.s2 & ~sync_q.s3;
        fall_seen = ~sync_q.s2 & sync_q.s3;
        case (edge_sel_e'(edge_sel))
            EDG_RISE: edge_hit = rise_seen;
            EDG_FALL: edge_hit = fall_seen;
            EDG_BOTH: edge_hit = rise_seen | fall_seen;
            default:  edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    AST_EDGE_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00) |-> !edge_hit);                              // R9
    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b01 && edge_hit) |-> sync_q.s2);                  // R9
endmodule

// File: rtl/cc_cmp_buf.sv
module cc_cmp_buf #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_en,
    input  logic [1:0]    cnt_mode,
    input  logic [2:0]    buf_mode,
    input  logic [CW-1:0] cnt_val,
    input  logic [CW-1:0] cnt_max,
    input  logic [CW-1:0] ch_val,
    output logic          match_o,
    output logic          reload_o
);
    import cc_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cbuf;
        logic          match;
        logic          reload;
    } cmp_t;

    cmp_t      cmp_d, cmp_q;
    logic      hit;
    logic      at_zero;
    logic      at_max;
    logic      one_way;
    logic      load;
    buf_mode_e bm;
    cnt_mode_e cm;

    always_comb begin
        bm      = buf_mode_e'(buf_mode);
        cm      = cnt_mode_e'(cnt_mode);
        cmp_d   = cmp_q;
        hit     = (cnt_val == cmp_q.cbuf);
        at_zero = (cnt_val == '0);
        at_max  = (cnt_val == cnt_max);
        one_way = (cm == CM_UP) || (cm == CM_DOWN);
        case (bm)
            BM_IMMED: load = 1'b1;
            BM_WRAP: begin
                case (cm)
                    CM_UP:   load = at_zero;
                    CM_DOWN: load = at_max;
                    default: load = at_zero | at_max;
                endcase
            end
            BM_MATCH_ZERO:             load = hit | at_zero;
            BM_MATCH_RST, BM_MATCH_RLD: load = hit;
            default:                   load = 1'b0;
        endcase
        if (capture_en) begin
            cmp_d.match  = 1'b0;
            cmp_d.reload = 1'b0;
        end else begin
            cmp_d.match  = hit;
            cmp_d.reload = hit && one_way &&
                           ((bm == BM_MATCH_RST) || (bm == BM_MATCH_RLD));
            if (load) cmp_d.cbuf = ch_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign match_o  = cmp_q.match;
    assign reload_o = cmp_q.reload;

    AST_RELOAD_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> match_o);                                           // R6
    AST_BUF_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> $stable(cmp_q.cbuf));                             // R8
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode >= 3'd5) |=> $stable(cmp_q.cbuf));                     // R7
    AST_NO_MATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> !match_o);                                        // R8
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
    parameter int CW    = 16,
    parameter int NTRIG = 4,
    localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             sync_cap,
    input  logic [1:0]       cnt_mode,
    input  logic [2:0]       buf_mode,
    input  logic [TSW-1:0]   trig_sel,
    input  logic [1:0]       edge_sel,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [CW-1:0]    cnt_val,
    input  logic [CW-1:0]    cnt_max,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_data,
    input  logic             flag_clr,
    output logic             match_o,
    output logic             reload_o,
    output logic [CW-1:0]    cap_val_o,
    output logic             cap_flag_o,
    output logic             cap_ovf_o
);
    typedef struct packed {
        logic [CW-1:0] ch;
        logic          flag;
        logic          ovf;
        logic          edge_dly;
    } chan_t;

    chan_t chan_d, chan_q;
    logic  edge_hit;
    logic  cap_now;

    cc_trig_detect #(.NTRIG(NTRIG)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .trig_sel (trig_sel),
        .edge_sel (edge_sel),
        .edge_hit (edge_hit)
    );

    cc_cmp_buf #(.CW(CW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .cnt_mode   (cnt_mode),
        .buf_mode   (buf_mode),
        .cnt_val    (cnt_val),
        .cnt_max    (cnt_max),
        .ch_val     (chan_q.ch),
        .match_o    (match_o),
        .reload_o   (reload_o)
    );

    always_comb begin
        chan_d          = chan_q;
        chan_d.edge_dly = edge_hit & capture_en & sync_cap;
        cap_now         = capture_en & (sync_cap ? chan_q.edge_dly : edge_hit);
        if (cap_now)    chan_d.ch = cnt_val;
        else if (wr_en) chan_d.ch = wr_data;
        chan_d.flag = cap_now | (chan_q.flag & ~flag_clr);
        chan_d.ovf  = (cap_now & chan_q.flag & ~flag_clr) | (chan_q.ovf & ~flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign cap_val_o  = chan_q.ch;
    assign cap_flag_o = chan_q.flag;
    assign cap_ovf_o  = chan_q.ovf;

    AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ovf_o |-> cap_flag_o);                                       // R12
    AST_ASYNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !sync_cap && edge_hit) |=> cap_flag_o);           // R10
    AST_COMPARE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !chan_q.edge_dly && !cap_flag_o) |=> !cap_flag_o); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_now) |=> (!cap_flag_o && !cap_ovf_o));         // R12
endmodule

// File: tb/cc_channel_bench.sv
module cc_channel_bench;
    localparam int CW = 16;
    localparam int NTRIG = 4;
    localparam int TSW = 2;
    localparam int NV = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             capture_en = 1'b0;
    logic             sync_cap = 1'b0;
    logic [1:0]       cnt_mode = '0;
    logic [2:0]       buf_mode = '0;
    logic [TSW-1:0]   trig_sel = '0;
    logic [1:0]       edge_sel = '0;
    logic [NTRIG-1:0] trig_in = '0;
    logic [CW-1:0]    cnt_val = '0;
    logic [CW-1:0]    cnt_max = 16'h00FF;
    logic             wr_en = 1'b0;
    logic [CW-1:0]    wr_data = '0;
    logic             flag_clr = 1'b0;
    logic             match_o, reload_o, cap_flag_o, cap_ovf_o;
    logic [CW-1:0]    cap_val_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cc_channel #(.CW(CW), .NTRIG(NTRIG)) u_cc_channel (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .sync_cap(sync_cap),
        .cnt_mode(cnt_mode), .buf_mode(buf_mode), .trig_sel(trig_sel),
        .edge_sel(edge_sel), .trig_in(trig_in), .cnt_val(cnt_val),
        .cnt_max(cnt_max), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
        .match_o(match_o), .reload_o(reload_o), .cap_val_o(cap_val_o),
        .cap_flag_o(cap_flag_o), .cap_ovf_o(cap_ovf_o)
    );

    // {capture, cnt_mode, buf_mode, wr, wdata, cnt, exp_match, exp_reload}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'd0, 1'b1, 16'h0010, 16'h0005, 1'b0, 1'b0}, // R3
        {1'b0, 2'd0, 3'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R2
        {1'b0, 2'd0, 3'd0, 1'b0, 16'h0000, 16'h0010, 1'b1, 1'b0}, // R3
        {1'b0, 2'd0, 3'd4, 1'b1, 16'h0020, 16'h0010, 1'b1, 1'b1}, // R6
        {1'b0, 2'd0, 3'd4, 1'b0, 16'h0000, 16'h0020, 1'b0, 1'b0}, // R6
        {1'b0, 2'd0, 3'd4, 1'b0, 16'h0000, 16'h0010, 1'b1, 1'b1}, // R6
        {1'b0, 2'd0, 3'd4, 1'b0, 16'h0000, 16'h0020, 1'b1, 1'b1}, // R6
        {1'b0, 2'd1, 3'd3, 1'b1, 16'h0030, 16'h0005, 1'b0, 1'b0}, // R6
        {1'b0, 2'd1, 3'd3, 1'b0, 16'h0000, 16'h0020, 1'b1, 1'b1}, // R6
        {1'b0, 2'd2, 3'd3, 1'b0, 16'h0000, 16'h0030, 1'b1, 1'b0}, // R6
        {1'b0, 2'd0, 3'd1, 1'b1, 16'h0040, 16'h0007, 1'b0, 1'b0}, // R4
        {1'b0, 2'd0, 3'd1, 1'b0, 16'h0000, 16'h0030, 1'b1, 1'b0}, // R4
        {1'b0, 2'd0, 3'd1, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R4
        {1'b0, 2'd0, 3'd1, 1'b0, 16'h0000, 16'h0040, 1'b1, 1'b0}, // R4
        {1'b0, 2'd1, 3'd1, 1'b1, 16'h0050, 16'h0000, 1'b0, 1'b0}, // R4
        {1'b0, 2'd1, 3'd1, 1'b0, 16'h0000, 16'h0050, 1'b0, 1'b0}, // R4
        {1'b0, 2'd1, 3'd1, 1'b0, 16'h0000, 16'h00FF, 1'b0, 1'b0}, // R4
        {1'b0, 2'd1, 3'd1, 1'b0, 16'h0000, 16'h0050, 1'b1, 1'b0}, // R4
        {1'b0, 2'd0, 3'd2, 1'b1, 16'h0060, 16'h0003, 1'b0, 1'b0}, // R5
        {1'b0, 2'd0, 3'd2, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R5
        {1'b0, 2'd0, 3'd2, 1'b0, 16'h0000, 16'h0060, 1'b1, 1'b0}, // R5
        {1'b0, 2'd0, 3'd5, 1'b1, 16'h0070, 16'h0001, 1'b0, 1'b0}, // R7
        {1'b0, 2'd0, 3'd5, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R7
        {1'b0, 2'd0, 3'd5, 1'b0, 16'h0000, 16'h0060, 1'b1, 1'b0}, // R7
        {1'b0, 2'd0, 3'd5, 1'b0, 16'h0000, 16'h0070, 1'b0, 1'b0}, // R7
        {1'b1, 2'd0, 3'd0, 1'b0, 16'h0000, 16'h0060, 1'b0, 1'b0}, // R8
        {1'b0, 2'd0, 3'd5, 1'b0, 16'h0000, 16'h0060, 1'b1, 1'b0}, // R8
        {1'b0, 2'd0, 3'd5, 1'b0, 16'h0000, 16'h0061, 1'b0, 1'b0}, // R2
        {1'b0, 2'd0, 3'd2, 1'b0, 16'h0000, 16'h0060, 1'b1, 1'b0}, // R5
        {1'b0, 2'd0, 3'd5, 1'b0, 16'h0000, 16'h0070, 1'b1, 1'b0}  // R5
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(32'(match_o),    0, "R1 match");
        chk(32'(reload_o),   0, "R1 reload");
        chk(32'(cap_val_o),  0, "R1 cap value");
        chk(32'(cap_flag_o), 0, "R1 flag");
        chk(32'(cap_ovf_o),  0, "R1 overflow");

        for (int i = 0; i < NV; i++) begin
            {capture_en, cnt_mode, buf_mode, wr_en, wr_data, cnt_val} = VEC[i][40:2];
            tick();
            chk(32'(match_o),  32'(VEC[i][1]), $sformatf("R2 vector %0d match", i));
            chk(32'(reload_o), 32'(VEC[i][0]), $sformatf("R6 vector %0d reload", i));
        end
        wr_en = 1'b0;

        // R10: asynchronous rising capture on line 2
        capture_en = 1'b1; buf_mode = 3'd0; trig_sel = 2'd2; edge_sel = 2'b01; sync_cap = 1'b0;
        tick(); tick(); tick();
        trig_in[2] = 1'b1; cnt_val = 16'h1001; tick();
        chk(32'(cap_flag_o), 0, "R10 no early flag");
        cnt_val = 16'h1002; tick();
        cnt_val = 16'h1003; tick();
        chk(32'(cap_val_o),  32'h1003, "R10 async value");
        chk(32'(cap_flag_o), 1, "R10 flag set");
        chk(32'(cap_ovf_o),  0, "R12 no overflow");

        // R9: falling edge ignored with rising select
        trig_in[2] = 1'b0;
        for (int k = 0; k < 5; k++) begin cnt_val = 16'h1100 + 16'(k); tick(); end
        chk(32'(cap_val_o), 32'h1003, "R9 falling ignored");
        chk(32'(cap_ovf_o), 0, "R9 no overflow");

        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk(32'(cap_flag_o), 0, "R12 flag cleared");

        // R11: synchronous both-edge capture
        edge_sel = 2'b11; sync_cap = 1'b1;
        trig_in[2] = 1'b1; cnt_val = 16'h2001; tick();
        cnt_val = 16'h2002; tick();
        cnt_val = 16'h2003; tick();
        chk(32'(cap_flag_o), 0, "R11 not yet captured");
        cnt_val = 16'h2004; tick();
        chk(32'(cap_val_o),  32'h2004, "R11 sync value");
        chk(32'(cap_flag_o), 1, "R11 flag set");

        // R12: falling edge while flag set gives overflow
        trig_in[2] = 1'b0;
        cnt_val = 16'h3001; tick();
        cnt_val = 16'h3002; tick();
        cnt_val = 16'h3003; tick();
        cnt_val = 16'h3004; tick();
        chk(32'(cap_val_o), 32'h3004, "R9 falling captured");
        chk(32'(cap_ovf_o), 1, "R12 overflow set");
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk(32'(cap_flag_o), 0, "R12 flag cleared again");
        chk(32'(cap_ovf_o),  0, "R12 overflow cleared");

        // R9: unselected line ignored
        edge_sel = 2'b01; sync_cap = 1'b0;
        trig_in[0] = 1'b1;
        for (int k = 0; k < 5; k++) begin cnt_val = 16'h4000 + 16'(k); tick(); end
        chk(32'(cap_flag_o), 0, "R9 other line ignored");
        chk(32'(cap_val_o), 32'h3004, "R9 value unchanged");
        trig_in[0] = 1'b0;

        // R8: comparator mode ignores the trigger
        capture_en = 1'b0; buf_mode = 3'd5;
        tick(); tick();
        trig_in[2] = 1'b1;
        for (int k = 0; k < 5; k++) begin cnt_val = 16'h5000 + 16'(k); tick(); end
        chk(32'(cap_flag_o), 0, "R8 no capture in comparator mode");
        chk(32'(cap_val_o), 32'h3004, "R8 register unchanged");

        report();
    end
endmodule